// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the memory address for a single load or store. It also forms the value that may be written back to the base register. It takes a base register value, a 12-bit unsigned immediate, an index register value, a shift amount, the program counter and a set of mode controls. From these it produces the access address, the write-back value, a write-back enable and an alignment fault flag for the requested access size. All of this is computed in one combinational pass and captured in a single output register stage. That stage carries a valid flag.

One datapath serves five addressing forms, each with its own write-back rule: plain pre-indexed, pre-indexed with write-back, post-indexed, register offset with an optional left shift (in pre or post form), and PC-relative. An add/subtract control sets the sign of the offset.

The output stage is a two-state machine. ST_EMPTY means no result is presented. ST_LOADED means a result is presented. The transition EMPTY->LOADED happens on a cycle with `in_valid` high. The transition LOADED->LOADED happens when another request arrives back to back. The transition LOADED->EMPTY happens when no request arrives. The transition EMPTY->EMPTY happens while the block is idle.

Top module: `ls_addr_gen`

## Requirements
- R1: With `in_mode` = 2'b00 (plain pre-index), `out_addr` = base + offset and `out_wb_en` = 0.
- R2: With `in_mode` = 2'b01 (pre-index with write-back), `out_addr` = base + offset, `out_wb_value` equals `out_addr`, and `out_wb_en` = 1.
- R3: With `in_mode` = 2'b10 (post-index), `out_addr` = the unmodified base, `out_wb_value` = base + offset, and `out_wb_en` = 1.
- R4: The offset is selected as follows.
  - When `in_use_reg` = 1, the offset is `in_index` shifted left by `in_shamt`.
  - When `in_use_reg` = 0, the offset is the zero-extended `in_imm`, and `in_shamt` and `in_index` have no effect.
- R5: Post-index mode with `in_use_reg` = 1 writes back base + (`in_index` << `in_shamt`), while the access uses the base.
- R6: With `in_mode` = 2'b11 (PC-relative), `out_addr` = `in_pc` + zero-extended `in_imm`, and `out_wb_en` = 0. In this mode `in_use_reg`, `in_index` and `in_base` have no effect on `out_addr`.
- R7: With `in_sub` = 1, the offset is subtracted instead of added, modulo 2^DATA_W. This applies to every mode.
- R8: The `in_size` encoding is 0 = byte, 1 = halfword, 2 = word, 3 = treated as word. `out_align_fault` is set under these conditions, and is never set for byte accesses:
  - a halfword access with `out_addr` bit 0 set;
  - a word access with either of `out_addr` bits 1:0 set.
- R9: A request sampled with `in_valid` high at a rising edge appears on the outputs after that edge with `out_valid` high. An edge with `in_valid` low drops `out_valid` and leaves the data outputs unchanged.
- R10: After reset, `out_valid`, `out_wb_en`, `out_align_fault`, `out_addr` and `out_wb_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 2 | 00 pre, 01 pre with write-back, 10 post, 11 PC-relative |
| in_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| in_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| in_use_reg | input | 1 | 1 selects the shifted index register as offset |
| in_base | input | DATA_W | Base register value |
| in_imm | input | IMM_W | Unsigned immediate offset |
| in_index | input | DATA_W | Index register value |
| in_shamt | input | SHAMT_W | Left shift applied to the index |
| in_pc | input | DATA_W | Program counter value |
| out_valid | output | 1 | Result registers hold a fresh result |
| out_addr | output | DATA_W | Effective access address |
| out_wb_value | output | DATA_W | Value for base register write-back |
| out_wb_en | output | 1 | Write-back requested |
| out_align_fault | output | 1 | Access misaligned for its size |

## Verification
The bound checker enforces several properties on every cycle:
- the one-cycle valid timing;
- the hold of the address while idle;
- the absence of write-back for plain pre-index and PC-relative requests;
- the use of the raw base as the post-index address;
- the equality of address and write-back value in pre-index write-back mode;
- the absence of faults on byte accesses.

The arithmetic itself can only be shown by the scoreboard scenarios. These cover:
- the add and subtract results;
- scaling by the shift amount;
- the immediate path ignoring the shift and index;
- the PC-relative path ignoring the base;
- the halfword and word fault patterns.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        AM_PRE    = 2'b00,
        AM_PRE_WB = 2'b01,
        AM_POST   = 2'b10,
        AM_PCREL  = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } asize_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } ostate_e;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [IMM_W-1:0]   imm,
    input  logic [DATA_W-1:0]  index,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               use_reg,
    input  logic               pcrel,
    output logic [DATA_W-1:0]  offset
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] idx_scaled;

    assign imm_ext    = {{PAD_W{1'b0}}, imm};
    assign idx_scaled = index << shamt;

    // PC-relative forms always take the immediate.
    always_comb begin
        if (use_reg && !pcrel) offset = idx_scaled;
        else                   offset = imm_ext;
    end
endmodule

// File: rtl/agu_adder.sv
module agu_adder
    import agu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] offset,
    input  logic              sub,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] wb_value,
    output logic              wb_en
);
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] sum;

    always_comb begin
        opnd_a = (mode == AM_PCREL) ? pc : base;
        sum    = sub ? (opnd_a - offset) : (opnd_a + offset);
        unique case (mode)
            AM_PRE: begin
                addr  = sum;
                wb_en = 1'b0;
            end
            AM_PRE_WB: begin
                addr  = sum;
                wb_en = 1'b1;
            end
            AM_POST: begin
                addr  = base;
                wb_en = 1'b1;
            end
            default: begin
                addr  = sum;
                wb_en = 1'b0;
            end
        endcase
        wb_value = sum;
    end
endmodule

// File: rtl/agu_align.sv
module agu_align
    import agu_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       fault
);
    always_comb begin
        unique case (size)
            SZ_BYTE: fault = 1'b0;
            SZ_HALF: fault = addr_lo[0];
            default: fault = |addr_lo;
        endcase
    end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import agu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_mode,
    input  logic [1:0]         in_size,
    input  logic               in_sub,
    input  logic               in_use_reg,
    input  logic [DATA_W-1:0]  in_base,
    input  logic [IMM_W-1:0]   in_imm,
    input  logic [DATA_W-1:0]  in_index,
    input  logic [SHAMT_W-1:0] in_shamt,
    input  logic [DATA_W-1:0]  in_pc,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_addr,
    output logic [DATA_W-1:0]  out_wb_value,
    output logic               out_wb_en,
    output logic               out_align_fault
);
    ostate_e           state_q;
    ostate_e           state_d;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] addr_c;
    logic [DATA_W-1:0] wbv_c;
    logic              wbe_c;
    logic              fault_c;

    agu_offset #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_off (
        .imm     (in_imm),
        .index   (in_index),
        .shamt   (in_shamt),
        .use_reg (in_use_reg),
        .pcrel   (in_mode == AM_PCREL),
        .offset  (offset)
    );

    agu_adder #(.DATA_W(DATA_W)) u_add (
        .base     (in_base),
        .pc       (in_pc),
        .offset   (offset),
        .sub      (in_sub),
        .mode     (in_mode),
        .addr     (addr_c),
        .wb_value (wbv_c),
        .wb_en    (wbe_c)
    );

    agu_align u_aln (
        .addr_lo (addr_c[1:0]),
        .size    (in_size),
        .fault   (fault_c)
    );

    // Next-state selection.
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output registers: loaded on each accepted request, held otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr        <= '0;
            out_wb_value    <= '0;
            out_wb_en       <= 1'b0;
            out_align_fault <= 1'b0;
        end else if (in_valid) begin
            out_addr        <= addr_c;
            out_wb_value    <= wbv_c;
            out_wb_en       <= wbe_c;
            out_align_fault <= fault_c;
        end
    end

    assign out_valid = (state_q == ST_LOADED);
endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk
    import agu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_mode,
    input logic [1:0]        in_size,
    input logic [DATA_W-1:0] in_base,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_wb_value,
    input logic              out_wb_en,
    input logic              out_align_fault
);
    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_addr)));

    // R1
    pre_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == AM_PRE) |=> !out_wb_en);

    // R6
    pcrel_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == AM_PCREL) |=> !out_wb_en);

    // R2
    prewb_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == AM_PRE_WB) |=> (out_wb_en && out_wb_value == out_addr));

    // R3
    post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == AM_POST) |=> (out_wb_en && out_addr == $past(in_base)));

    // R8
    byte_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == SZ_BYTE) |=> !out_align_fault);
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_mode         (in_mode),
    .in_size         (in_size),
    .in_base         (in_base),
    .out_valid       (out_valid),
    .out_addr        (out_addr),
    .out_wb_value    (out_wb_value),
    .out_wb_en       (out_wb_en),
    .out_align_fault (out_align_fault)
);

// File: tb/ls_addr_gen_tb.sv
`timescale 1ns/1ps
module ls_addr_gen_tb;
    localparam int DW = 32;
    localparam int IW = 12;
    localparam int SW = 5;

    typedef struct {
        logic [DW-1:0] addr;
        logic [DW-1:0] wbv;
        logic          wbe;
        logic          fault;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_mode = '0;
    logic [1:0]    in_size = '0;
    logic          in_sub = 1'b0;
    logic          in_use_reg = 1'b0;
    logic [DW-1:0] in_base = '0;
    logic [IW-1:0] in_imm = '0;
    logic [DW-1:0] in_index = '0;
    logic [SW-1:0] in_shamt = '0;
    logic [DW-1:0] in_pc = '0;
    logic          out_valid;
    logic [DW-1:0] out_addr;
    logic [DW-1:0] out_wb_value;
    logic          out_wb_en;
    logic          out_align_fault;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    logic [DW-1:0] last_addr = '0;

    always #2 clk = ~clk;

    ls_addr_gen #(.DATA_W(DW), .IMM_W(IW), .SHAMT_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_size(in_size), .in_sub(in_sub), .in_use_reg(in_use_reg),
        .in_base(in_base), .in_imm(in_imm), .in_index(in_index),
        .in_shamt(in_shamt), .in_pc(in_pc), .out_valid(out_valid),
        .out_addr(out_addr), .out_wb_value(out_wb_value),
        .out_wb_en(out_wb_en), .out_align_fault(out_align_fault)
    );

    function automatic exp_t predict(input logic [1:0] m, input logic [1:0] sz,
                                     input logic sb_, input logic ur,
                                     input logic [DW-1:0] b, input logic [IW-1:0] im,
                                     input logic [DW-1:0] ix, input logic [SW-1:0] sh,
                                     input logic [DW-1:0] p, input string rq);
        exp_t e;
        logic [DW-1:0] off, src, res;
        if (m == 2'b11)  off = DW'(im);
        else if (ur)     off = ix << sh;
        else             off = DW'(im);
        src = (m == 2'b11) ? p : b;
        res = sb_ ? src - off : src + off;
        e.addr  = (m == 2'b10) ? b : res;
        e.wbv   = res;
        e.wbe   = (m == 2'b01) || (m == 2'b10);
        if (sz == 2'd0)      e.fault = 1'b0;
        else if (sz == 2'd1) e.fault = e.addr[0];
        else                 e.fault = e.addr[1] | e.addr[0];
        e.req = rq;
        return e;
    endfunction

    task automatic issue(input logic [1:0] m, input logic [1:0] sz, input logic sb_,
                         input logic ur, input logic [DW-1:0] b, input logic [IW-1:0] im,
                         input logic [DW-1:0] ix, input logic [SW-1:0] sh,
                         input logic [DW-1:0] p, input string rq);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_size = sz; in_sub = sb_; in_use_reg = ur;
        in_base = b; in_imm = im; in_index = ix; in_shamt = sh; in_pc = p;
        sb.push_back(predict(m, sz, sb_, ur, b, im, ix, sh, p, rq));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_base = 32'hDEAD_BEE0; in_pc = 32'h1234_5678; in_imm = 12'hFFF;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R9: out_valid=1 actual, expected 0 (no pending item)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                last_addr = e.addr;
                if (out_addr !== e.addr || out_wb_value !== e.wbv ||
                    out_wb_en !== e.wbe || out_align_fault !== e.fault) begin
                    n_bad++;
                    $display("FAIL %s: actual addr=%h wbv=%h wbe=%b flt=%b expected addr=%h wbv=%h wbe=%b flt=%b",
                             e.req, out_addr, out_wb_value, out_wb_en, out_align_fault,
                             e.addr, e.wbv, e.wbe, e.fault);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        n_cmp++;
        if (out_valid !== 1'b0 || out_addr !== '0 || out_wb_value !== '0 ||
            out_wb_en !== 1'b0 || out_align_fault !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: actual v=%b a=%h w=%h e=%b f=%b expected all zero",
                     out_valid, out_addr, out_wb_value, out_wb_en, out_align_fault);
        end
        rst_n = 1'b1;

        // R1 plain pre-index immediate
        issue(2'b00, 2'd2, 0, 0, 32'h2000_0100, 12'h004, 32'h0, 5'd0, 32'h0, "R1");
        // R2 pre-index write-back
        issue(2'b01, 2'd2, 0, 0, 32'h2000_0100, 12'h010, 32'h0, 5'd0, 32'h0, "R2");
        // R3 post-index immediate
        issue(2'b10, 2'd2, 0, 0, 32'h2000_0200, 12'h008, 32'h0, 5'd0, 32'h0, "R3");
        // R4 register offset unshifted
        issue(2'b00, 2'd0, 0, 1, 32'h0000_1000, 12'h000, 32'h0000_0033, 5'd0, 32'h0, "R4");
        // R4 scaled index for word lookup
        issue(2'b00, 2'd2, 0, 1, 32'h0000_1000, 12'h000, 32'h0000_0006, 5'd2, 32'h0, "R4");
        // R4 shift and index ignored with immediate offset
        issue(2'b00, 2'd0, 0, 0, 32'h0000_1000, 12'h00C, 32'hFFFF_0000, 5'd7, 32'h0, "R4");
        // R5 post-index scaled register
        issue(2'b10, 2'd2, 0, 1, 32'h2000_0300, 12'h000, 32'h0000_0003, 5'd2, 32'h0, "R5");
        // R6 PC-relative, use_reg and index ignored
        issue(2'b11, 2'd2, 0, 1, 32'hAAAA_0000, 12'h0F0, 32'h0000_0100, 5'd4, 32'h0800_0010, "R6");
        // R7 subtract, pre with write-back
        issue(2'b01, 2'd2, 1, 0, 32'h2000_0100, 12'h004, 32'h0, 5'd0, 32'h0, "R7");
        // R7 subtract with wrap below zero
        issue(2'b00, 2'd0, 1, 1, 32'h0000_0002, 12'h000, 32'h0000_0001, 5'd2, 32'h0, "R7");
        // R7 subtract in PC-relative
        issue(2'b11, 2'd1, 1, 0, 32'h0, 12'h010, 32'h0, 5'd0, 32'h0000_0100, "R7");
        // R8 halfword odd address faults
        issue(2'b00, 2'd1, 0, 0, 32'h0000_1000, 12'h001, 32'h0, 5'd0, 32'h0, "R8");
        // R8 halfword even, bit 1 set, no fault
        issue(2'b00, 2'd1, 0, 0, 32'h0000_1000, 12'h002, 32'h0, 5'd0, 32'h0, "R8");
        // R8 word with bit 1 set faults
        issue(2'b00, 2'd2, 0, 0, 32'h0000_1000, 12'h002, 32'h0, 5'd0, 32'h0, "R8");
        // R8 reserved size treated as word, bit 0 set
        issue(2'b00, 2'd3, 0, 0, 32'h0000_1001, 12'h000, 32'h0, 5'd0, 32'h0, "R8");
        // R8 byte odd address never faults
        issue(2'b00, 2'd0, 0, 0, 32'h0000_1003, 12'h000, 32'h0, 5'd0, 32'h0, "R8");
        // R8 post-index: fault follows the base, not the write-back sum
        issue(2'b10, 2'd2, 0, 0, 32'h0000_1000, 12'h003, 32'h0, 5'd0, 32'h0, "R8");

        // R9 idle: valid drops, data held
        idle();
        idle();
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || out_addr !== last_addr) begin
            n_bad++;
            $display("FAIL R9: actual v=%b a=%h expected v=0 a=%h", out_valid, out_addr, last_addr);
        end

        // R9 single request after idle
        issue(2'b01, 2'd2, 0, 1, 32'h1000_0000, 12'h000, 32'h0000_0010, 5'd4, 32'h0, "R9");
        idle();
        repeat (3) @(negedge clk);
        n_cmp++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R9: actual %0d items pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule